// File: doc/BRIEF.md
# Programmable Output Colour Matrix

This block turns every valid three-component pixel into a new three-component pixel through a 3x4 affine transform. Each output channel is a weighted sum of the three input components plus an additive offset. The result is rounded half-up and clamped to the unsigned output range. A small register port holds twelve signed 2.13 entries and a mode value. The mode chooses pass-through, one of three fixed matrices (limited-range RGB, BT.601 YCbCr, BT.709 YCbCr) or the matrix loaded through the port.

Register writes go to a shadow set. A frame-start strobe copies the whole shadow set, matrix and mode together, into the working set. No frame is ever converted with a half-updated matrix. The pixel that arrives in the strobe cycle is already converted with the new set. Every result appears a fixed three cycles after its input, and the valid flag travels alongside the data.

Top module: `cmx_color_matrix`

## Requirements
- R1: While reset is held, out_valid is 0 and all three output channels are 0. After reset the working mode is pass-through and every stored entry is 0.
- R2: A pixel accepted with in_valid=1 produces out_valid=1 exactly three clock cycles later. Cycles with in_valid=0 produce out_valid=0 three cycles later.
- R3: A write to cfg_addr p (p = 0..5) stores cfg_wdata[15:0] into matrix entry 2p and cfg_wdata[31:16] into entry 2p+1. Entry index is 4*row+column, and column 3 of each row is that row's offset. cfg_addr 6 stores cfg_wdata[2:0] as the mode. cfg_addr 7 has no effect.
- R4: Register writes without a frame-start strobe leave the conversion of later pixels unchanged.
- R5: When frame_start is 1, the pixel accepted in that cycle uses the shadow set as it stood before that edge, and the shadow set becomes the working set. A write in the same cycle lands in the shadow set only and is not used until the next strobe.
- R6: Modes 0, 5, 6 and 7 pass each component through unchanged.
- R7: Mode 1 applies a gain of 0x1B60 on the diagonal with offset 0x0200 on every row.
- R8: Mode 2 applies the BT.601 matrix. Its rows are {0x0E00,0xF447,0xFDB9,0x1000}, {0x082F,0x1012,0x031F,0x0200} and {0xFB47,0xF6B9,0x0E00,0x1000}.
- R9: Mode 3 applies the BT.709 matrix. Its rows are {0x0E00,0xF349,0xFEB7,0x1000}, {0x05D2,0x1394,0x01FA,0x0200} and {0xFCCB,0xF535,0x0E00,0x1000}.
- R10: Mode 4 uses the loaded entries. Output row r = floor((C[r][0]*x0 + C[r][1]*x1 + C[r][2]*x2 + C[r][3]*2^DW + 4096) / 8192), with the entries read as signed 16-bit values.
- R11: A row result below 0 is output as 0, and a result above 2^DW-1 is output as 2^DW-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address: 0..5 entry pairs, 6 mode |
| cfg_wdata | input | 2*CW | Write data, two entries per word |
| frame_start | input | 1 | Copies the shadow set into the working set |
| in_valid | input | 1 | Input pixel valid |
| in_c0 | input | DW | Input component 0 |
| in_c1 | input | DW | Input component 1 |
| in_c2 | input | DW | Input component 2 |
| out_valid | output | 1 | Output pixel valid |
| out_c0 | output | DW | Output row 0 result |
| out_c1 | output | DW | Output row 1 result |
| out_c2 | output | DW | Output row 2 result |

## Verification
Three things can fall in one cycle: the frame-start transfer, a register write and an accepted pixel. The bench raises frame_start together with a valid pixel, and once also together with a write to entry pair 0. It then checks three results. The pixel in that cycle must already reflect the new mode and matrix. The write must not reach the working set. The write must appear only after a later strobe. A reference model computes each result from the register state at the cycle the pixel was accepted, and this is compared with the design output three cycles later.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
   localparam int NUM_ROWS = 3;
   localparam int NUM_COLS = 4;
   localparam int NUM_ENT  = NUM_ROWS * NUM_COLS;
   localparam int NUM_PAIR = NUM_ENT / 2;
   localparam int ADDR_W   = 3;
   localparam int MODE_W   = 3;
   localparam int FRAC     = 13;
   localparam int FIX_W    = 16;
   localparam logic [ADDR_W-1:0] MODE_ADDR = 3'd6;

   typedef enum logic [MODE_W-1:0] {
      CMX_PASS   = 3'd0,
      CMX_LIMRGB = 3'd1,
      CMX_YUV601 = 3'd2,
      CMX_YUV709 = 3'd3,
      CMX_PROG   = 3'd4
   } cmx_mode_e;

   // built-in 2.13 matrices, entry index = 4*row + column
   function automatic logic [FIX_W-1:0] fixed_coef(input logic [MODE_W-1:0] m,
                                                   input logic [3:0] e);
      logic [FIX_W-1:0] t [NUM_ENT];
      case (m)
         CMX_LIMRGB: t = '{16'h1B60, 16'h0000, 16'h0000, 16'h0200,
                           16'h0000, 16'h1B60, 16'h0000, 16'h0200,
                           16'h0000, 16'h0000, 16'h1B60, 16'h0200};
         CMX_YUV601: t = '{16'h0E00, 16'hF447, 16'hFDB9, 16'h1000,
                           16'h082F, 16'h1012, 16'h031F, 16'h0200,
                           16'hFB47, 16'hF6B9, 16'h0E00, 16'h1000};
         CMX_YUV709: t = '{16'h0E00, 16'hF349, 16'hFEB7, 16'h1000,
                           16'h05D2, 16'h1394, 16'h01FA, 16'h0200,
                           16'hFCCB, 16'hF535, 16'h0E00, 16'h1000};
         default:    t = '{16'h2000, 16'h0000, 16'h0000, 16'h0000,
                           16'h0000, 16'h2000, 16'h0000, 16'h0000,
                           16'h0000, 16'h0000, 16'h2000, 16'h0000};
      endcase
      return t[e];
   endfunction
endpackage

// File: rtl/cmx_coef_bank.sv
module cmx_coef_bank import cmx_pkg::*; #(
   parameter int CW = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [ADDR_W-1:0]       cfg_addr,
   input  logic [2*CW-1:0]         cfg_wdata,
   input  logic                    frame_start,
   output logic [NUM_ENT*CW-1:0]   eff_coef,
   output logic [MODE_W-1:0]       eff_mode
);
   logic [CW-1:0]     shd_q [NUM_ENT];
   logic [CW-1:0]     act_q [NUM_ENT];
   logic [MODE_W-1:0] shd_mode_q;
   logic [MODE_W-1:0] act_mode_q;

   genvar e;
   generate
      for (e = 0; e < NUM_ENT; e++) begin : g_ent
         localparam logic [ADDR_W-1:0] PA = ADDR_W'(e / 2);
         localparam int                LO = (e % 2) * CW;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               shd_q[e] <= '0;
               act_q[e] <= '0;
            end else begin
               if (frame_start)
                  act_q[e] <= shd_q[e];
               if (cfg_we && cfg_addr == PA)
                  shd_q[e] <= cfg_wdata[LO +: CW];
            end
         end

         // the strobe cycle already sees the incoming set
         assign eff_coef[e*CW +: CW] = frame_start ? shd_q[e] : act_q[e];

         assert_shadow_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == PA) |=> shd_q[e] == $past(cfg_wdata[LO +: CW]));
         assert_active_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_start |=> $stable(act_q[e]));
         assert_transfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
            frame_start |=> act_q[e] == $past(shd_q[e]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shd_mode_q <= CMX_PASS;
         act_mode_q <= CMX_PASS;
      end else begin
         if (frame_start)
            act_mode_q <= shd_mode_q;
         if (cfg_we && cfg_addr == MODE_ADDR)
            shd_mode_q <= cfg_wdata[MODE_W-1:0];
      end
   end

   assign eff_mode = frame_start ? shd_mode_q : act_mode_q;

   assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(act_mode_q));
   assert_mode_transfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> act_mode_q == $past(shd_mode_q));
endmodule

// File: rtl/cmx_coef_select.sv
module cmx_coef_select import cmx_pkg::*; #(
   parameter int CW = 16
) (
   input  logic [MODE_W-1:0]     mode,
   input  logic [NUM_ENT*CW-1:0] prog_coef,
   output logic [NUM_ENT*CW-1:0] mtx
);
   genvar e;
   generate
      for (e = 0; e < NUM_ENT; e++) begin : g_sel
         always_comb begin
            if (mode == CMX_PROG)
               mtx[e*CW +: CW] = prog_coef[e*CW +: CW];
            else
               mtx[e*CW +: CW] = CW'($signed(fixed_coef(mode, 4'(e))));
         end
      end
   endgenerate
endmodule

// File: rtl/cmx_mac_pipe.sv
module cmx_mac_pipe import cmx_pkg::*; #(
   parameter int DW = 10,
   parameter int CW = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [NUM_ROWS*DW-1:0]  in_pix,
   input  logic [NUM_ENT*CW-1:0]   mtx,
   output logic                    out_valid,
   output logic [NUM_ROWS*DW-1:0]  out_pix
);
   localparam int PW    = CW + DW + 1;
   localparam int ACC_W = PW + 3;
   localparam int MAXV  = (1 << DW) - 1;
   localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1 << (FRAC - 1));
   localparam logic signed [ACC_W-1:0] MAX_S = ACC_W'(MAXV);

   logic       v1_q, v2_q, v3_q;
   logic [1:0] settle_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1_q     <= 1'b0;
         v2_q     <= 1'b0;
         v3_q     <= 1'b0;
         settle_q <= '0;
      end else begin
         v1_q <= in_valid;
         v2_q <= v1_q;
         v3_q <= v2_q;
         if (settle_q != 2'd3)
            settle_q <= settle_q + 2'd1;
      end
   end

   assign out_valid = v3_q;

   genvar r, c;
   generate
      for (r = 0; r < NUM_ROWS; r++) begin : g_row
         logic signed [PW-1:0]    prod_q [NUM_ROWS];
         logic signed [ACC_W-1:0] offs_q;
         logic signed [ACC_W-1:0] sum_q;
         logic signed [ACC_W-1:0] quo;
         logic [DW-1:0]           res_q;

         for (c = 0; c < NUM_ROWS; c++) begin : g_mul
            always_ff @(posedge clk) begin
               if (!rst_n)
                  prod_q[c] <= '0;
               else
                  prod_q[c] <= $signed(mtx[(r*NUM_COLS+c)*CW +: CW])
                             * $signed({1'b0, in_pix[c*DW +: DW]});
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               offs_q <= '0;
               sum_q  <= '0;
               res_q  <= '0;
            end else begin
               offs_q <= (ACC_W'($signed(mtx[(r*NUM_COLS+3)*CW +: CW]))) <<< DW;
               sum_q  <= ACC_W'(prod_q[0]) + ACC_W'(prod_q[1]) + ACC_W'(prod_q[2])
                       + offs_q + HALF;
               if (sum_q < 0)
                  res_q <= '0;
               else if (quo > MAX_S)
                  res_q <= DW'(MAXV);
               else
                  res_q <= quo[DW-1:0];
            end
         end

         assign quo = sum_q >>> FRAC;
         assign out_pix[r*DW +: DW] = res_q;

         assert_clamp_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (v2_q && sum_q < 0) |=> res_q == '0);
         assert_clamp_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (v2_q && (sum_q >>> FRAC) > MAX_S) |=> res_q == DW'(MAXV));
      end
   endgenerate

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (settle_q == 2'd3) |-> out_valid == $past(in_valid, 3));
endmodule

// File: rtl/cmx_color_matrix.sv
module cmx_color_matrix import cmx_pkg::*; #(
   parameter int DW = 10,
   parameter int CW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [2*CW-1:0]   cfg_wdata,
   input  logic              frame_start,
   input  logic              in_valid,
   input  logic [DW-1:0]     in_c0,
   input  logic [DW-1:0]     in_c1,
   input  logic [DW-1:0]     in_c2,
   output logic              out_valid,
   output logic [DW-1:0]     out_c0,
   output logic [DW-1:0]     out_c1,
   output logic [DW-1:0]     out_c2
);
   generate
      if (CW < FIX_W) begin : g_bad_cw
         $error("CW must hold a 16-bit 2.13 entry");
      end
      if (DW < 2 || DW > 16) begin : g_bad_dw
         $error("DW must lie in 2..16");
      end
   endgenerate

   logic [NUM_ENT*CW-1:0]  eff_coef;
   logic [NUM_ENT*CW-1:0]  mtx;
   logic [MODE_W-1:0]      eff_mode;
   logic [NUM_ROWS*DW-1:0] pix_in;
   logic [NUM_ROWS*DW-1:0] pix_out;

   assign pix_in = {in_c2, in_c1, in_c0};

   cmx_coef_bank #(.CW(CW)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_addr    (cfg_addr),
      .cfg_wdata   (cfg_wdata),
      .frame_start (frame_start),
      .eff_coef    (eff_coef),
      .eff_mode    (eff_mode)
   );

   cmx_coef_select #(.CW(CW)) u_sel (
      .mode      (eff_mode),
      .prog_coef (eff_coef),
      .mtx       (mtx)
   );

   cmx_mac_pipe #(.DW(DW), .CW(CW)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_pix    (pix_in),
      .mtx       (mtx),
      .out_valid (out_valid),
      .out_pix   (pix_out)
   );

   assign out_c0 = pix_out[0*DW +: DW];
   assign out_c1 = pix_out[1*DW +: DW];
   assign out_c2 = pix_out[2*DW +: DW];
endmodule

// File: tb/cmx_color_matrix_bench.sv
module cmx_color_matrix_bench;
   localparam int DW = 10;
   localparam int CW = 16;
   localparam int MAXV = (1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          frame_start = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
   logic          out_valid;
   logic [DW-1:0] out_c0, out_c1, out_c2;

   always #5 clk = ~clk;

   cmx_color_matrix #(.DW(DW), .CW(CW)) u_cmx_color_matrix (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
      .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2), .out_valid(out_valid),
      .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2));

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string cur_tag = "R1";

   int lim_t [12] = '{'h1B60, 0, 0, 'h0200, 0, 'h1B60, 0, 'h0200, 0, 0, 'h1B60, 'h0200};
   int y601_t[12] = '{'h0E00, 'hF447, 'hFDB9, 'h1000, 'h082F, 'h1012, 'h031F, 'h0200,
                      'hFB47, 'hF6B9, 'h0E00, 'h1000};
   int y709_t[12] = '{'h0E00, 'hF349, 'hFEB7, 'h1000, 'h05D2, 'h1394, 'h01FA, 'h0200,
                      'hFCCB, 'hF535, 'h0E00, 'h1000};

   // reference state
   int    shd[12];
   int    act[12];
   int    shd_mode, act_mode;
   bit    pv[3];
   int    pe[3][3];
   string pt[3];

   function automatic longint sx16(input int v);
      return (v >= 32768) ? longint'(v) - 65536 : longint'(v);
   endfunction

   function automatic int entry(input int m, input int e, input int prog[12]);
      case (m)
         1: return lim_t[e];
         2: return y601_t[e];
         3: return y709_t[e];
         4: return prog[e];
         default: return (e == 0 || e == 5 || e == 10) ? 'h2000 : 0;
      endcase
   endfunction

   function automatic int row_out(input int m, input int r, input int prog[12],
                                  input int x0, input int x1, input int x2);
      longint acc;
      longint q;
      acc = sx16(entry(m, 4*r, prog)) * x0 + sx16(entry(m, 4*r+1, prog)) * x1
          + sx16(entry(m, 4*r+2, prog)) * x2
          + sx16(entry(m, 4*r+3, prog)) * (longint'(1) << DW) + 4096;
      q = acc >>> 13;
      if (q < 0) return 0;
      if (q > MAXV) return MAXV;
      return int'(q);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (shd[i]) begin shd[i] = 0; act[i] = 0; end
         shd_mode = 0; act_mode = 0;
         for (int i = 0; i < 3; i++) pv[i] = 1'b0;
      end else begin
         int m;
         int src[12];
         m = frame_start ? shd_mode : act_mode;
         src = frame_start ? shd : act;
         pv[2] = pv[1]; pe[2] = pe[1]; pt[2] = pt[1];
         pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
         pv[0] = in_valid; pt[0] = cur_tag;
         for (int r = 0; r < 3; r++)
            pe[0][r] = row_out(m, r, src, int'(in_c0), int'(in_c1), int'(in_c2));
         if (frame_start) begin act = shd; act_mode = shd_mode; end
         if (cfg_we) begin
            if (cfg_addr < 6) begin
               shd[2*cfg_addr]   = int'(cfg_wdata[15:0]);
               shd[2*cfg_addr+1] = int'(cfg_wdata[31:16]);
            end else if (cfg_addr == 6) begin
               shd_mode = int'(cfg_wdata[2:0]);
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int act_o[3];
         act_o = '{int'(out_c0), int'(out_c1), int'(out_c2)};
         checks++;
         if (out_valid !== pv[2]) begin
            errors++;
            $display("FAIL R2 (%s) out_valid actual=%0b expected=%0b", pt[2], out_valid, pv[2]);
         end
         if (pv[2]) begin
            for (int r = 0; r < 3; r++) begin
               checks++;
               if (act_o[r] != pe[2][r]) begin
                  errors++;
                  $display("FAIL %s row %0d actual=%0d expected=%0d", pt[2], r, act_o[r], pe[2][r]);
               end
            end
         end
      end
   end

   task automatic cyc(input bit fs, input bit we, input int addr, input longint data,
                      input bit v, input int a, input int b, input int c, input string t);
      @(negedge clk);
      frame_start = fs; cfg_we = we; cfg_addr = 3'(addr); cfg_wdata = data[31:0];
      in_valid = v; in_c0 = DW'(a); in_c1 = DW'(b); in_c2 = DW'(c); cur_tag = t;
   endtask

   task automatic idle(input int n, input string t);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, t);
   endtask

   task automatic pix(input int a, input int b, input int c, input string t);
      cyc(0, 0, 0, 0, 1, a, b, c, t);
   endtask

   task automatic wr(input int addr, input longint data, input string t);
      cyc(0, 1, addr, data, 0, 0, 0, 0, t);
   endtask

   task automatic pixset(input string t);
      pix(0, 0, 0, t);
      pix(MAXV, MAXV, MAXV, t);
      pix(300, 600, 900, t);
      pix(1000, 20, 512, t);
   endtask

   initial begin
      // R1: reset state
      repeat (4) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_c0 !== '0 || out_c1 !== '0 || out_c2 !== '0) begin
         errors++;
         $display("FAIL R1 reset outputs actual=%0b/%0d/%0d/%0d expected=0/0/0/0",
                  out_valid, out_c0, out_c1, out_c2);
      end
      rst_n = 1'b1;

      // R6 pass-through after reset, with R2 gaps
      pix(0, 0, 0, "R6");
      pix(MAXV, 512, 1, "R6");
      idle(2, "R2");
      pix(5, 900, 77, "R6");
      idle(1, "R2");
      pix(1, 2, 3, "R2");

      // R7 limited RGB, R5 strobe together with a pixel
      wr(6, 1, "R6");
      cyc(1, 0, 0, 0, 1, 700, 100, 40, "R5");
      pixset("R7");
      // R8 BT.601
      wr(6, 2, "R7");
      cyc(1, 0, 0, 0, 1, 200, 800, 50, "R8");
      pixset("R8");
      // R9 BT.709
      wr(6, 3, "R8");
      cyc(1, 0, 0, 0, 1, 200, 800, 50, "R9");
      pixset("R9");

      // R4: load programmable set while streaming, no strobe
      wr(0, 32'h1000_1000, "R4");
      pix(3, 0, 9, "R4");
      wr(1, 32'h0000_0000, "R4");
      wr(2, 32'h0000_E000, "R4");
      pix(400, 400, 400, "R4");
      wr(3, 32'h0000_0000, "R4");
      wr(4, 32'h2000_2000, "R4");
      wr(5, 32'h0100_2000, "R4");
      wr(6, 4, "R4");
      pix(123, 456, 789, "R4");

      // R10 / R11 programmable matrix with rounding and clamping
      cyc(1, 0, 0, 0, 1, 3, 0, 5, "R10");
      pix(3, 0, 5, "R10");
      pix(1, 2, 0, "R10");
      pix(MAXV, MAXV, MAXV, "R11");
      pix(0, 0, 0, "R11");
      pix(900, 10, 20, "R11");
      pix(100, 50, 25, "R10");

      // R5: write in the strobe cycle goes only to the shadow set
      cyc(1, 1, 0, 32'h0000_2000, 1, 7, 9, 11, "R5");
      pix(7, 9, 11, "R5");
      pix(500, 300, 100, "R5");
      cyc(1, 0, 0, 0, 1, 7, 9, 11, "R5");
      pix(500, 300, 100, "R5");

      // R3: address 7 is ignored; mode 7 behaves as pass-through
      cyc(0, 1, 7, 32'hFFFF_FFFF, 0, 0, 0, 0, "R3");
      cyc(1, 0, 0, 0, 1, 41, 42, 43, "R3");
      pix(600, 601, 602, "R3");
      wr(6, 7, "R6");
      cyc(1, 0, 0, 0, 1, 41, 842, 1023, "R6");
      pix(17, 0, 333, "R6");
      idle(6, "R2");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule